// File: doc/BRIEF.md
# Phase-Preserving Reference Switch Corrector

This block sits in front of a timing loop and hands it one virtual reference built from whichever of two physical references is in use. Everything runs on a fast sampling clock. Only falling edges of the references matter: each falling edge of the selected input turns into a falling edge of the virtual output after a stored delay, counted in sampling-clock cycles.

When the reference controller rearranges the inputs (a switch pulse together with a select level), the block measures where the first falling edge of the new input sits relative to the grid of past virtual edges. It stores the delay that moves that edge onto the grid. So the virtual output keeps its phase across the switch and the loop downstream sees no step. An active-low alignment input, held low long enough, clears the stored delay so that virtual edges coincide with the raw selected reference again. A two-bit frequency code picks the nominal reference period used for the modulo arithmetic and for the width of the regenerated low phase.

Top module: `ref_phase_keeper`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `virt_ref` is 1, `virt_edge` is 0 and `code_err` is 0. The stored delay restarts at zero and the primary input (`ref_pri`) is selected.
- R2: A falling edge of the selected reference (low at a clock edge, high at the edge before) gives a one-cycle `virt_edge` pulse delayed by the stored delay. With a delay of zero the pulse is high right after that same clock edge. Falling edges of the input that is not selected make no pulse.
- R3: On a cycle with `switch_pulse` = 1, the block selects `ref_sec` if `sel_sec` = 1, else `ref_pri`. At the first falling edge of the newly selected input, detected n cycles after the last virtual edge, the stored delay becomes (P - n mod P) mod P, with P the nominal period in cycles.
- R4: Every later falling edge of the selected input is delayed by the same stored delay, so each virtual edge falls on the pre-switch grid and no expected edge is lost.
- R5: `virt_ref` goes low in the same cycle that `virt_edge` is high and stays low for floor(P/2) cycles before it returns high.
- R6: Once `align_n` has been sampled low on ALIGN_MIN consecutive clock edges, the next falling edge of the selected input clears the stored delay to zero and passes without delay. Any pending measurement is dropped.
- R7: A low pulse on `align_n` shorter than ALIGN_MIN sampled cycles has no effect on the stored delay.
- R8: `freq_code` sets P: 2'b00 gives PER_T1 cycles, 2'b01 gives PER_E1 cycles and 2'b11 gives PER_8K cycles. The new value takes effect one cycle after the code is applied.
- R9: The code 2'b10 is invalid. While it is applied, P keeps its last valid value and a measurement that completes does not change the stored delay. `code_err` goes to 1 one cycle after the code is first seen and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_pri | input | 1 | Primary reference level, synchronous to clk |
| ref_sec | input | 1 | Secondary reference level, synchronous to clk |
| sel_sec | input | 1 | Selection applied on a switch: 1 secondary, 0 primary |
| switch_pulse | input | 1 | One-cycle request to rearrange references |
| freq_code | input | 2 | Nominal reference frequency code |
| align_n | input | 1 | Alignment request, active low, width-qualified |
| virt_ref | output | 1 | Regenerated virtual reference level |
| virt_edge | output | 1 | One-cycle strobe on each virtual falling edge |
| code_err | output | 1 | Sticky flag for an invalid frequency code |

## Verification
On every cycle the embedded properties check a number of local rules. A zero delay gives a strobe on the next cycle. The strobe always coincides with a low level. A completed measurement stays below the period. An armed alignment forces the delay to zero. The error flag never clears, and the period and delay hold while the invalid code is applied. An alignment can arm only after a low sample. Phase preservation itself needs the bench's scenarios: the exact cycle of each virtual edge is predicted across switches in both directions, at two periods, after short and long alignment pulses and under the invalid code, and each predicted edge must appear with no extra edges between them.

// File: rtl/rpk_pkg.sv
package rpk_pkg;
  typedef enum logic [1:0] {
    FREQ_T1  = 2'b00,
    FREQ_E1  = 2'b01,
    FREQ_RSV = 2'b10,
    FREQ_8K  = 2'b11
  } freq_code_e;
endpackage

// File: rtl/rpk_edge_det.sv
module rpk_edge_det #(
  parameter int NREF = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREF-1:0] ref_in,
  output logic [NREF-1:0] fall
);
  for (genvar i = 0; i < NREF; i++) begin : g_ref
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= ref_in[i];
    end
    assign fall[i] = prev_q & ~ref_in[i];
  end
endmodule

// File: rtl/rpk_align_qual.sv
module rpk_align_qual #(
  parameter int MIN_LOW = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic align_n,
  input  logic consume,
  output logic armed
);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      armed  <= 1'b0;
    end else begin
      if (align_n)                        lo_cnt <= '0;
      else if (lo_cnt != LW'(MIN_LOW))    lo_cnt <= lo_cnt + LW'(1);
      if (!align_n && lo_cnt == LW'(MIN_LOW - 1)) armed <= 1'b1;
      else if (consume)                           armed <= 1'b0;
    end
  end

  AST_ARM_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(!align_n)); // R7
endmodule

// File: rtl/rpk_phase_meas.sv
module rpk_phase_meas #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per,
  input  logic          fire,
  input  logic          switch_req,
  input  logic          sel_req,
  input  logic          fall_pri,
  input  logic          fall_sec,
  input  logic          armed,
  input  logic          rsv,
  output logic          fall_sel,
  output logic [CW-1:0] load_ofs,
  output logic          consume
);
  logic          use_sec;
  logic          measuring;
  logic [CW-1:0] ph;
  logic [CW-1:0] offset;
  logic [CW-1:0] grid_ofs;

  assign fall_sel = use_sec ? fall_sec : fall_pri;
  assign consume  = fall_sel & armed;
  assign grid_ofs = per - CW'(1) - ph;

  always_comb begin
    if (armed)                 load_ofs = '0;
    else if (measuring && !rsv) load_ofs = grid_ofs;
    else                       load_ofs = offset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      use_sec   <= 1'b0;
      measuring <= 1'b0;
      ph        <= '0;
      offset    <= '0;
    end else begin
      if (fire)                     ph <= '0;
      else if (ph >= per - CW'(1))  ph <= '0;
      else                          ph <= ph + CW'(1);

      if (fall_sel) offset <= load_ofs;

      if (switch_req) begin
        use_sec   <= sel_req;
        measuring <= 1'b1;
      end else if (fall_sel) begin
        measuring <= 1'b0;
      end
    end
  end

  AST_RSV_KEEP: assert property (@(posedge clk) disable iff (rst)
    (fall_sel && !armed && rsv) |=> $stable(offset)); // R9
  AST_ARM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fall_sel && armed) |=> (offset == '0)); // R6
  AST_OFS_BELOW_PER: assert property (@(posedge clk) disable iff (rst)
    (fall_sel && measuring && !armed && !rsv && !switch_req) |=> (offset < per)); // R3
endmodule

// File: rtl/rpk_delay_gen.sv
module rpk_delay_gen #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per,
  input  logic          fall_sel,
  input  logic [CW-1:0] load_ofs,
  output logic          fire,
  output logic          virt_edge,
  output logic          virt_ref
);
  logic          pend;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lvl_cnt;

  always_comb begin
    if (fall_sel) fire = (load_ofs == '0);
    else          fire = pend && (cnt == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      cnt       <= '0;
      lvl_cnt   <= '0;
      virt_edge <= 1'b0;
      virt_ref  <= 1'b1;
    end else begin
      if (fall_sel) begin
        pend <= (load_ofs != '0);
        cnt  <= load_ofs;
      end else if (pend) begin
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) pend <= 1'b0;
      end

      virt_edge <= fire;

      if (fire) begin
        virt_ref <= 1'b0;
        lvl_cnt  <= per >> 1;
      end else if (!virt_ref) begin
        if (lvl_cnt <= CW'(1)) virt_ref <= 1'b1;
        else                   lvl_cnt  <= lvl_cnt - CW'(1);
      end
    end
  end

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (fall_sel && (load_ofs == '0)) |=> virt_edge); // R2
  AST_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
    virt_edge |-> !virt_ref); // R5
endmodule

// File: rtl/ref_phase_keeper.sv
module ref_phase_keeper
  import rpk_pkg::*;
#(
  parameter int PER_T1    = 12,
  parameter int PER_E1    = 16,
  parameter int PER_8K    = 40,
  parameter int ALIGN_MIN = 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_pri,
  input  logic       ref_sec,
  input  logic       sel_sec,
  input  logic       switch_pulse,
  input  logic [1:0] freq_code,
  input  logic       align_n,
  output logic       virt_ref,
  output logic       virt_edge,
  output logic       code_err
);
  localparam int PER_AB  = (PER_T1 > PER_E1) ? PER_T1 : PER_E1;
  localparam int PER_MAX = (PER_AB > PER_8K) ? PER_AB : PER_8K;
  localparam int CW      = $clog2(PER_MAX + 1);

  logic [1:0]    falls;
  logic [CW-1:0] per_q;
  logic [CW-1:0] per_pick;
  logic          rsv;
  logic          armed;
  logic          consume;
  logic          fall_sel;
  logic [CW-1:0] load_ofs;
  logic          fire;

  assign rsv = (freq_code == FREQ_RSV);

  always_comb begin
    case (freq_code)
      FREQ_E1: per_pick = CW'(PER_E1);
      FREQ_8K: per_pick = CW'(PER_8K);
      default: per_pick = CW'(PER_T1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q    <= CW'(PER_T1);
      code_err <= 1'b0;
    end else begin
      if (!rsv) per_q    <= per_pick;
      else      code_err <= 1'b1;
    end
  end

  rpk_edge_det #(.NREF(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .ref_in ({ref_sec, ref_pri}),
    .fall   (falls)
  );

  rpk_align_qual #(.MIN_LOW(ALIGN_MIN)) u_align (
    .clk     (clk),
    .rst     (rst),
    .align_n (align_n),
    .consume (consume),
    .armed   (armed)
  );

  rpk_phase_meas #(.CW(CW)) u_meas (
    .clk        (clk),
    .rst        (rst),
    .per        (per_q),
    .fire       (fire),
    .switch_req (switch_pulse),
    .sel_req    (sel_sec),
    .fall_pri   (falls[0]),
    .fall_sec   (falls[1]),
    .armed      (armed),
    .rsv        (rsv),
    .fall_sel   (fall_sel),
    .load_ofs   (load_ofs),
    .consume    (consume)
  );

  rpk_delay_gen #(.CW(CW)) u_dly (
    .clk       (clk),
    .rst       (rst),
    .per       (per_q),
    .fall_sel  (fall_sel),
    .load_ofs  (load_ofs),
    .fire      (fire),
    .virt_edge (virt_edge),
    .virt_ref  (virt_ref)
  );

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    code_err |=> code_err); // R9
  AST_PER_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsv |=> $stable(per_q)); // R9
endmodule

// File: tb/ref_phase_keeper_bench.sv
module ref_phase_keeper_bench;
  localparam int AMIN = 13;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, ref_pri = 1'b0, ref_sec = 1'b0, sel_sec = 1'b0, switch_pulse = 1'b0;
  logic [1:0] freq_code = 2'b00;
  logic align_n = 1'b1;
  logic virt_ref, virt_edge, code_err;

  ref_phase_keeper #(.PER_T1(12), .PER_E1(16), .PER_8K(40), .ALIGN_MIN(AMIN)) u_ref_phase_keeper (
    .clk(clk), .rst(rst), .ref_pri(ref_pri), .ref_sec(ref_sec), .sel_sec(sel_sec),
    .switch_pulse(switch_pulse), .freq_code(freq_code), .align_n(align_n),
    .virt_ref(virt_ref), .virt_edge(virt_edge), .code_err(code_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nerr = 0;
  bit done = 0;
  string req_tag = "R2";
  bit rst_b = 1, sel_b = 0, lvl_en = 0;
  logic [1:0] fc_b = 2'b00;
  int per_b = 12, offp = 0, offs = 5;
  bit act_m = 0, meas_m = 0, armed_m = 0, prevp = 0, prevs = 0;
  int lowcnt = 0, d_m = 0, last_v = 0, lowrun = 0;
  int exp_q[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies one sample and predicts the resulting virtual edge
  task automatic step(bit sw, bit al_n);
    int s;
    bit np, ns, fp, fs, fsel;
    @(negedge clk);
    s  = cyc + 1;
    np = ((s + offp) % per_b) >= per_b / 2;
    ns = ((s + offs) % per_b) >= per_b / 2;
    rst = rst_b; ref_pri = np; ref_sec = ns; sel_sec = sel_b;
    switch_pulse = sw; freq_code = fc_b; align_n = al_n;
    if (rst_b) begin
      prevp = 0; prevs = 0; act_m = 0; meas_m = 0; armed_m = 0; lowcnt = 0; d_m = 0;
      return;
    end
    fp = prevp & !np; fs = prevs & !ns; prevp = np; prevs = ns;
    fsel = act_m ? fs : fp;
    if (fsel) begin
      if (armed_m) begin d_m = 0; meas_m = 0; armed_m = 0; end
      else if (meas_m) begin
        if (fc_b != 2'b10) d_m = (per_b - ((s - last_v) % per_b)) % per_b;
        meas_m = 0;
      end
      last_v = s + d_m;
      exp_q.push_back(last_v);
    end
    if (sw) begin act_m = sel_b; meas_m = 1; end
    if (al_n) lowcnt = 0;
    else begin
      if (lowcnt == AMIN - 1) armed_m = 1;
      if (lowcnt < AMIN) lowcnt++;
    end
  endtask

  task automatic do_switch(bit to_sec);
    while (cyc + 1 <= last_v) step(0, 1);
    sel_b = to_sec;
    step(1, 1);
  endtask

  // monitor: pops expected edge times and checks level width
  always @(negedge clk) begin
    if (!rst_b && !done) begin
      if (virt_edge) begin
        if (exp_q.size() == 0) chk(0, req_tag, "unexpected virtual edge at cycle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(cyc == e, req_tag, "virtual edge cycle", cyc, e);
        end
      end
      if (!virt_ref) lowrun++;
      else begin
        if (lowrun > 0 && lvl_en) chk(lowrun == per_b / 2, "R5", "low phase width", lowrun, per_b / 2);
        lowrun = 0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) step(0, 1);
    chk(virt_ref == 1'b1, "R1", "virt_ref in reset", virt_ref, 1);
    chk(virt_edge == 1'b0, "R1", "virt_edge in reset", virt_edge, 0);
    chk(code_err == 1'b0, "R1", "code_err in reset", code_err, 0);
    rst_b = 0;
    step(0, 1);
    chk(virt_ref == 1'b1 && virt_edge == 1'b0 && code_err == 1'b0, "R1", "outputs after reset",
        {virt_ref, virt_edge, code_err}, 3'b100);
    lvl_en = 1;
    req_tag = "R2"; repeat (60) step(0, 1);
    // secondary grid is 5 cycles off: delay 5 expected
    req_tag = "R3"; do_switch(1); repeat (40) step(0, 1);
    req_tag = "R4"; offp = 3; repeat (40) step(0, 1);
    req_tag = "R3"; do_switch(0); repeat (60) step(0, 1);
    req_tag = "R7"; repeat (4) step(0, 0); repeat (40) step(0, 1);
    req_tag = "R6"; lvl_en = 0; repeat (15) step(0, 0); repeat (30) step(0, 1);
    lvl_en = 1; repeat (30) step(0, 1);
    req_tag = "R9"; lvl_en = 0; fc_b = 2'b10; repeat (3) step(0, 1);
    chk(code_err == 1'b1, "R9", "code_err after invalid code", code_err, 1);
    do_switch(1); repeat (40) step(0, 1);
    fc_b = 2'b00; repeat (3) step(0, 1);
    chk(code_err == 1'b1, "R9", "code_err sticky", code_err, 1);
    req_tag = "R8"; fc_b = 2'b01; per_b = 16; repeat (40) step(0, 1);
    lvl_en = 1; repeat (50) step(0, 1);
    req_tag = "R3"; do_switch(0); repeat (60) step(0, 1);
    req_tag = "R8"; lvl_en = 0; repeat (15) step(0, 0); repeat (20) step(0, 1);
    fc_b = 2'b11; per_b = 40; repeat (100) step(0, 1);
    lvl_en = 1; repeat (130) step(0, 1);
    lvl_en = 0; req_tag = "R4";
    repeat (60) step(0, 1);
    chk(exp_q.size() == 0, "R4", "expected edges left unseen", exp_q.size(), 0);
    finish_run();
  end
endmodule